// File: doc/BRIEF.md
# Indirect Core Register Access Bridge

This block sits between a 64-bit host command register and a small bank of byte-wide registers inside a serial bus controller core. Software puts one 64-bit word into the register. If the launch flag in that word is set, the bridge turns the word into a single read or write on a request/acknowledge port into the core, or into a one-cycle soft reset pulse. While that work is pending, the launch flag reads back as set. When the work is done, the bridge clears the flag. For a read, it also puts the byte returned by the core into the low byte of the register.

Software starts a command by writing the word. It then polls the register until bit 63 reads as zero, and takes the result from the low byte. Core access happens only under the extended opcode (value 6 in bits 60:57). A three-bit selector in bits 34:32 then names the target: 1 is the data register, 2 is control, 3 is clock control for a write or status for a read, and 7 is a soft reset. Any other opcode, and any other selector under the extended opcode, finishes at once without touching the core.

The core port is a request/acknowledge handshake. The request is held high for exactly one cycle. The core may acknowledge in that same cycle or in any later cycle. The core may hold off the acknowledge for as long as it needs. That delay is the port's only back-pressure, and the bridge keeps the selector, the read flag and the write byte stable until the acknowledge arrives. An acknowledge that arrives when no access is outstanding is ignored.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the command register reads as all zeros, and neither `core_req` nor `core_soft_rst` is asserted.
- R2: A host write taken while bit 63 is clear, and whose bit 63 is set, launches a command. From the next cycle, bit 63 reads as 1 until the command completes.
- R3: A launched command with opcode 6 (bits 60:57) and selector 1, 2 or 3 (bits 34:32) raises `core_req` for exactly one cycle, in the cycle after the host write. During that cycle `core_sel` equals bits 34:32, `core_rd` equals bit 56 and `core_wdata` equals bits 7:0. These three outputs hold until the acknowledge.
- R4: On the clock edge where `core_ack` is high during an outstanding access (the request cycle or any cycle after it), bit 63 clears. If bit 56 is 1 (read), bits 7:0 take the value of `core_rdata` at that edge. All other bits are kept.
- R5: A core write (bit 56 clear) completes with the register equal to the command word with bit 63 cleared.
- R6: A host write taken while bit 63 reads as 1 is ignored: the register contents, the core port outputs and the result are unaffected.
- R7: A launched command whose opcode is not 6 raises neither `core_req` nor `core_soft_rst`. Bit 63 is set for one cycle and then clears, leaving the other bits as written.
- R8: A launched command with opcode 6 and selector 7 raises `core_soft_rst` for exactly one cycle, in the cycle after the host write, without `core_req`. Bit 63 clears on the following edge.
- R9: A launched command with opcode 6 and selector 0, 4, 5 or 6 completes like R7, without touching the core.
- R10: `core_ack` arriving while no access is outstanding does not change the register.
- R11: A host write with bit 63 clear, taken while idle, stores the word unchanged and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the command register |
| host_wr_data | input | 64 | Command word being written |
| host_rd_data | output | 64 | Current command register contents (flag, fields, result byte) |
| core_req | output | 1 | One-cycle access request to the core |
| core_sel | output | 3 | Core register selector |
| core_rd | output | 1 | 1 = read access, 0 = write access |
| core_wdata | output | 8 | Byte to write into the core register |
| core_ack | input | 1 | Core completion pulse |
| core_rdata | input | 8 | Read byte from the core, valid with `core_ack` |
| core_soft_rst | output | 1 | One-cycle soft reset pulse to the core |

## Verification
A sequencer stuck in its wait state shows at the ports as bit 63 never dropping after an acknowledge, one cycle after the acknowledge edge. A command word corrupted by a write taken while busy shows as changed non-flag bits, or a wrong result byte, at the completion readback. A wrong decode shows in the very first cycle after the launch: a request or reset pulse where none belongs, or a missing one, and this is checked at that cycle for every launch. A request that lasts more than one cycle, or a result byte latched on the wrong edge, shows within one cycle of the handshake.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  // Command word layout (positions are decoded by software, keep fixed)
  localparam int CMD_W     = 64;
  localparam int VALID_BIT = 63;
  localparam int OP_LO     = 57;
  localparam int OP_W      = 4;
  localparam int RD_BIT    = 56;
  localparam int SEL_LO    = 32;
  localparam int SEL_W     = 3;
  localparam int BYTE_W    = 8;

  localparam logic [OP_W-1:0]  OP_EXTENDED = 4'd6;
  localparam logic [SEL_W-1:0] SEL_DATA    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CLKSTAT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_RESET   = 3'd7;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_CORE  = 2'd1,
    K_RESET = 2'd2
  } cmd_kind_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_WAIT = 3'd2,
    S_RST  = 3'd3,
    S_DONE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_kind_t        kind
);
  logic [OP_W-1:0]  op;
  logic [SEL_W-1:0] sel;

  assign op  = word[OP_LO +: OP_W];
  assign sel = word[SEL_LO +: SEL_W];

  always_comb begin
    kind = K_NONE;
    if (op == OP_EXTENDED) begin
      unique case (sel)
        SEL_DATA, SEL_CTRL, SEL_CLKSTAT: kind = K_CORE;
        SEL_RESET:                       kind = K_RESET;
        default:                         kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch,
  input  cmd_kind_t kind,
  input  logic      core_ack,
  output logic      core_req,
  output logic      core_soft_rst,
  output logic      accept_ack,
  output logic      finish
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (launch) begin
        unique case (kind)
          K_CORE:  st_d = S_REQ;
          K_RESET: st_d = S_RST;
          default: st_d = S_DONE;
        endcase
      end
      S_REQ:   st_d = core_ack ? S_IDLE : S_WAIT;
      S_WAIT:  if (core_ack) st_d = S_IDLE;
      S_RST:   st_d = S_IDLE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign core_req      = (st_q == S_REQ);
  assign core_soft_rst = (st_q == S_RST);
  assign accept_ack    = core_ack && ((st_q == S_REQ) || (st_q == S_WAIT));
  assign finish        = accept_ack || (st_q == S_RST) || (st_q == S_DONE);

  // R3: request is a single-cycle pulse
  p_req_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |=> !core_req);
  // R8: reset pulse lasts one cycle
  p_rst_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_soft_rst |=> !core_soft_rst);
  // R8: reset and request never overlap
  p_req_rst_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_req && core_soft_rst));
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [CMD_W-1:0]  host_wr_data,
  output logic [CMD_W-1:0]  host_rd_data,
  output logic              core_req,
  output logic [SEL_W-1:0]  core_sel,
  output logic              core_rd,
  output logic [BYTE_W-1:0] core_wdata,
  input  logic              core_ack,
  input  logic [BYTE_W-1:0] core_rdata,
  output logic              core_soft_rst
);
  logic [CMD_W-1:0] cmd_q;
  logic             busy;
  logic             take_wr;
  logic             launch;
  logic             accept_ack;
  logic             finish;
  cmd_kind_t        new_kind;

  assign busy    = cmd_q[VALID_BIT];
  assign take_wr = host_wr_en && !busy;
  assign launch  = take_wr && host_wr_data[VALID_BIT];

  ibr_decode u_dec (
    .word (host_wr_data),
    .kind (new_kind)
  );

  ibr_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch        (launch),
    .kind          (new_kind),
    .core_ack      (core_ack),
    .core_req      (core_req),
    .core_soft_rst (core_soft_rst),
    .accept_ack    (accept_ack),
    .finish        (finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (take_wr) begin
      cmd_q <= host_wr_data;
    end else if (finish) begin
      cmd_q[VALID_BIT] <= 1'b0;
      if (accept_ack && cmd_q[RD_BIT])
        cmd_q[BYTE_W-1:0] <= core_rdata;
    end
  end

  assign host_rd_data = cmd_q;
  assign core_sel     = cmd_q[SEL_LO +: SEL_W];
  assign core_rd      = cmd_q[RD_BIT];
  assign core_wdata   = cmd_q[BYTE_W-1:0];

  // R6: word is frozen while busy until the completing edge
  p_busy_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(cmd_q));
  // R4: accepted acknowledge drops the flag on that edge
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ack |=> !host_rd_data[VALID_BIT]);
  // R3: request only for a pending extended-opcode command
  p_req_ext_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (busy && cmd_q[OP_LO +: OP_W] == OP_EXTENDED));
  // R8: reset pulse only for selector 7
  p_rst_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_soft_rst |-> (busy && cmd_q[SEL_LO +: SEL_W] == SEL_RESET));
  // R7: non-core command clears after one busy cycle
  p_quick_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && new_kind == K_NONE) |=> busy ##1 !busy);
endmodule

// File: tb/ibr_bridge_test.sv
module ibr_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] VMASK = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [63:0] host_wr_data = '0;
  logic [63:0] host_rd_data;
  logic        core_req, core_rd, core_soft_rst;
  logic [2:0]  core_sel;
  logic [7:0]  core_wdata;
  logic        core_ack = 1'b0;
  logic [7:0]  core_rdata = '0;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibr_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .core_req(core_req), .core_sel(core_sel),
    .core_rd(core_rd), .core_wdata(core_wdata), .core_ack(core_ack),
    .core_rdata(core_rdata), .core_soft_rst(core_soft_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 = no core work, 1 = core access, 2 = soft reset
  function automatic int exp_kind(input logic [63:0] w);
    if (w[60:57] != 4'd6) return 0;
    if (w[34:32] >= 3'd1 && w[34:32] <= 3'd3) return 1;
    if (w[34:32] == 3'd7) return 2;
    return 0;
  endfunction

  function automatic logic [63:0] exp_result(input logic [63:0] w, input logic [7:0] rb);
    logic [63:0] r;
    r = w & ~VMASK;
    if (exp_kind(w) == 1 && w[56]) r[7:0] = rb;
    return r;
  endfunction

  function automatic logic [63:0] mk(input bit v, input logic [3:0] op, input bit rd,
                                     input logic [2:0] sel, input logic [7:0] d, input logic [63:0] noise);
    logic [63:0] w;
    w = noise;
    w[63] = v; w[60:57] = op; w[56] = rd; w[34:32] = sel; w[7:0] = d;
    return w;
  endfunction

  task automatic run_cmd(input logic [63:0] w, input int lat, input bit poke);
    int k;
    logic [7:0] rb;
    k = exp_kind(w);
    @(negedge clk); host_wr_en = 1'b1; host_wr_data = w;
    @(negedge clk); host_wr_en = 1'b0; host_wr_data = '0;
    if (!w[63]) begin
      chk(host_rd_data == w, "R11 stored", host_rd_data, w);
      chk(!core_req && !core_soft_rst, "R11 no start", {62'd0, core_req, core_soft_rst}, 64'd0);
      return;
    end
    chk(host_rd_data[63] == 1'b1, "R2 busy flag", host_rd_data, w);
    if (k == 1) begin
      chk(core_req && !core_soft_rst, "R3 request", {62'd0, core_req, core_soft_rst}, 64'd2);
      chk(core_sel == w[34:32] && core_rd == w[56] && core_wdata == w[7:0], "R3 fields",
          {52'd0, core_sel, core_rd, core_wdata}, {52'd0, w[34:32], w[56], w[7:0]});
      for (int i = 0; i < lat; i++) begin
        if (poke && i == 0) begin
          host_wr_en = 1'b1;
          host_wr_data = {1'b1, 63'(~w[62:0])};
        end
        @(negedge clk);
        host_wr_en = 1'b0; host_wr_data = '0;
        chk(host_rd_data[63] && !core_req, "R2 busy while waiting", host_rd_data, w);
        chk(core_sel == w[34:32] && core_wdata == w[7:0], "R6 fields held",
            {53'd0, core_sel, core_wdata}, {53'd0, w[34:32], w[7:0]});
      end
      rb = 8'($urandom);
      core_ack = 1'b1; core_rdata = rb;
      @(negedge clk);
      core_ack = 1'b0; core_rdata = 8'($urandom);
      chk(host_rd_data == exp_result(w, rb), w[56] ? "R4 read result" : "R5 write result",
          host_rd_data, exp_result(w, rb));
      if (poke) chk(host_rd_data == exp_result(w, rb), "R6 busy write ignored", host_rd_data, exp_result(w, rb));
      chk(!core_req, "R3 no second request", {63'd0, core_req}, 64'd0);
    end else if (k == 2) begin
      chk(core_soft_rst && !core_req, "R8 reset pulse", {62'd0, core_req, core_soft_rst}, 64'd1);
      @(negedge clk);
      chk(!core_soft_rst, "R8 pulse ends", {63'd0, core_soft_rst}, 64'd0);
      chk(host_rd_data == exp_result(w, 8'd0), "R8 done", host_rd_data, exp_result(w, 8'd0));
    end else begin
      chk(!core_req && !core_soft_rst, (w[60:57] == 4'd6) ? "R9 untouched" : "R7 untouched",
          {62'd0, core_req, core_soft_rst}, 64'd0);
      @(negedge clk);
      chk(host_rd_data == exp_result(w, 8'd0), (w[60:57] == 4'd6) ? "R9 done" : "R7 done",
          host_rd_data, exp_result(w, 8'd0));
    end
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rd_data == 64'd0, "R1 reset value", host_rd_data, 64'd0);
    chk(!core_req && !core_soft_rst, "R1 outputs idle", {62'd0, core_req, core_soft_rst}, 64'd0);

    run_cmd(mk(1, 4'd6, 0, 3'd1, 8'h5A, 64'h0000_1234_0000_AB00), 0, 0);
    run_cmd(mk(1, 4'd6, 1, 3'd2, 8'h00, 64'h0), 2, 1);
    run_cmd(mk(1, 4'd6, 1, 3'd3, 8'hFF, 64'h00FF_0000_0000_0000), 3, 1);
    run_cmd(mk(1, 4'd6, 0, 3'd7, 8'h11, 64'h0), 0, 0);
    run_cmd(mk(1, 4'd6, 1, 3'd0, 8'h22, 64'h0), 0, 0);
    run_cmd(mk(1, 4'd6, 0, 3'd5, 8'h33, 64'h0), 0, 0);
    run_cmd(mk(1, 4'd0, 1, 3'd1, 8'h44, 64'h0), 0, 0);
    run_cmd(mk(1, 4'd4, 0, 3'd2, 8'h55, 64'h0), 0, 0);
    run_cmd(mk(0, 4'd6, 1, 3'd1, 8'h66, 64'h0), 0, 0);

    held = host_rd_data;
    @(negedge clk); core_ack = 1'b1; core_rdata = 8'hA5;
    @(negedge clk); core_ack = 1'b0;
    chk(host_rd_data == held && !core_req, "R10 stray ack", host_rd_data, held);

    for (int n = 0; n < 80; n++) begin
      logic [3:0] op;
      op = ($urandom % 4 != 0) ? 4'd6 : 4'($urandom);
      run_cmd(mk(($urandom % 8) != 0, op, 1'($urandom), 3'($urandom), 8'($urandom),
                 {$urandom, $urandom}), int'($urandom % 5), 1'($urandom));
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule